// File: doc/BRIEF.md
# Seven-Segment Digit Driver

This block turns one 4-bit decimal digit into the seven segment drives for a common-anode display. A common-anode display lights a segment when its line is pulled low, so every segment output is active low. Three active-low control inputs modify what is shown: a lamp check that lights every segment, a dark control that turns every segment off, and a zero-suppress input that blanks the digit when it is zero.

A zero-suppress output goes low exactly when this digit was suppressed as a leading zero. Several drivers can therefore be chained from the most significant digit downwards, each driver's suppress output feeding the suppress input of the next lower digit. That chain blanks leading zeros and stops at the first nonzero digit. A parameter selects whether the outputs come from a register stage (the default, one clock of latency and a defined reset value) or straight from the decode logic.

Top module: `digit_seg_driver`

## Requirements
- R1: With all three controls high, digit codes 0 to 9 light the usual glyphs. Output bit 0 is segment a, then b, c, d, e, f in order, and bit 6 is segment g; a lit segment reads 0. The lit segment sets are: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg (with its top tail), 7=abc, 8=abcdefg, 9=abcdfg (with its bottom tail).
- R2: With all controls high, digit codes 10 to 15 leave every segment off (all outputs 1).
- R3: A low lamp check lights every segment (outputs all 0) for any digit. It wins over the dark control and the zero-suppress input, and the suppress output stays high.
- R4: A low dark control, with lamp check high, turns every segment off for any digit, and the suppress output stays high.
- R5: With lamp check and dark control high, a low zero-suppress input together with digit 0 turns every segment off and drives the suppress output low.
- R6: A low zero-suppress input with a nonzero digit shows that digit normally with the suppress output high. A high zero-suppress input with digit 0 shows the 0 glyph with the suppress output high.
- R7: With REG_OUT=1, outputs follow the inputs captured at the previous rising clock edge. During reset the segments are all off (all 1) and the suppress output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| digit_i | input | 4 | Decimal digit code to display |
| lamp_chk_n | input | 1 | Lamp check, active low: light all segments |
| dark_n | input | 1 | Dark control, active low: all segments off |
| zsup_in_n | input | 1 | Zero-suppress input, active low |
| seg_n_o | output | 7 | Segment drives a..g at bits 0..6, active low |
| zsup_out_n | output | 1 | Low when this digit was suppressed as a leading zero |

## Verification
The hardest case to reach is the one where the controls compete. A low lamp check must win while the dark and zero-suppress inputs are also low. A zero digit must be suppressed only when the dark control is inactive, and the suppress output must stay high while the display is forced dark. The stimulus walks every digit code under each single control. It then applies the overlapping combinations (lamp check with dark, lamp check with suppress on zero, dark with suppress on zero) and changes the inputs on back-to-back cycles, so each registered result has to belong to exactly the previous cycle's inputs.

// File: rtl/seg_glyph_pkg.sv
package seg_glyph_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned SEG_W   = 7;
  localparam int unsigned MAX_DEC = 9;

  typedef logic [SEG_W-1:0]   seg_t;
  typedef logic [DIGIT_W-1:0] digit_t;

  // Lit-segment set (active high, bit0=a .. bit6=g) for a digit code.
  function automatic seg_t glyph_lit(input digit_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'b0111111;
      4'd1:    s = 7'b0000110;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1001111;
      4'd4:    s = 7'b1100110;
      4'd5:    s = 7'b1101101;
      4'd6:    s = 7'b1111101;
      4'd7:    s = 7'b0000111;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1101111;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/glyph_decode.sv
module glyph_decode
  import seg_glyph_pkg::*;
(
  input  digit_t digit,
  output seg_t   glyph_n,
  output logic   is_zero,
  output logic   is_invalid
);
  assign glyph_n    = ~glyph_lit(digit);
  assign is_zero    = (digit == '0);
  assign is_invalid = (int'(digit) > int'(MAX_DEC));

  always_comb begin
    if (is_invalid) assert (glyph_n == '1) else $error("invalid code lit a segment"); // R2
  end
endmodule

// File: rtl/blank_arbiter.sv
module blank_arbiter
  import seg_glyph_pkg::*;
(
  input  seg_t glyph_n,
  input  logic is_zero,
  input  logic lamp_chk_n,
  input  logic dark_n,
  input  logic zsup_in_n,
  output seg_t seg_n,
  output logic zsup_out_n,
  output logic ev_lamp,
  output logic ev_dark,
  output logic ev_zero_sup
);
  // Priority: lamp check > dark > zero suppress > normal decode.
  assign ev_lamp     = !lamp_chk_n;
  assign ev_dark     = lamp_chk_n && !dark_n;
  assign ev_zero_sup = lamp_chk_n && dark_n && !zsup_in_n && is_zero;

  always_comb begin
    if (ev_lamp)                    seg_n = '0;
    else if (ev_dark || ev_zero_sup) seg_n = '1;
    else                            seg_n = glyph_n;
  end

  assign zsup_out_n = !ev_zero_sup;

  always_comb begin
    assert ($countones({ev_lamp, ev_dark, ev_zero_sup}) <= 1) else $error("overlapping control events"); // R3
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_glyph_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  seg_t seg_d,
  input  logic zsup_d,
  output seg_t seg_q,
  output logic zsup_q
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          seg_q  <= '1;
          zsup_q <= 1'b1;
        end else begin
          seg_q  <= seg_d;
          zsup_q <= zsup_d;
        end
      end
    end else begin : g_comb
      assign seg_q  = seg_d;
      assign zsup_q = zsup_d;
    end
  endgenerate
endmodule

// File: rtl/digit_seg_driver.sv
module digit_seg_driver
  import seg_glyph_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic               lamp_chk_n,
  input  logic               dark_n,
  input  logic               zsup_in_n,
  output logic [SEG_W-1:0]   seg_n_o,
  output logic               zsup_out_n
);
  seg_t glyph_n, seg_next;
  logic is_zero, is_invalid, zsup_next;
  logic ev_lamp, ev_dark, ev_zero_sup;

  glyph_decode u_dec (
    .digit(digit_i), .glyph_n(glyph_n), .is_zero(is_zero), .is_invalid(is_invalid)
  );

  blank_arbiter u_arb (
    .glyph_n(glyph_n), .is_zero(is_zero), .lamp_chk_n(lamp_chk_n), .dark_n(dark_n),
    .zsup_in_n(zsup_in_n), .seg_n(seg_next), .zsup_out_n(zsup_next),
    .ev_lamp(ev_lamp), .ev_dark(ev_dark), .ev_zero_sup(ev_zero_sup)
  );

  seg_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .seg_d(seg_next), .zsup_d(zsup_next),
    .seg_q(seg_n_o), .zsup_q(zsup_out_n)
  );

  generate
    if (REG_OUT) begin : g_chk
      AST_LAMP_ALL_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        !lamp_chk_n |=> (seg_n_o == '0) && zsup_out_n); // R3
      AST_DARK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_chk_n && !dark_n) |=> (seg_n_o == '1) && zsup_out_n); // R4
      AST_ZERO_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_chk_n && dark_n && !zsup_in_n && digit_i == '0) |=> (seg_n_o == '1) && !zsup_out_n); // R5
      AST_ZSUP_ONLY_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !zsup_out_n |-> ($past(digit_i) == '0) && !$past(zsup_in_n)); // R6
      AST_HIGH_CODES_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_chk_n && dark_n && is_invalid) |=> (seg_n_o == '1)); // R2
    end
  endgenerate
endmodule

// File: tb/sim_digit_seg_driver.sv
`timescale 1ns/1ps
module sim_digit_seg_driver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] digit = 4'd0;
  logic       lt_n = 1'b1, dk_n = 1'b1, zi_n = 1'b1;
  logic [6:0] seg_n;
  logic       zo_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  digit_seg_driver #(.REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .digit_i(digit), .lamp_chk_n(lt_n), .dark_n(dk_n),
    .zsup_in_n(zi_n), .seg_n_o(seg_n), .zsup_out_n(zo_n)
  );

  // Bench's own glyph model: list of lit segment letters per digit.
  function automatic logic [6:0] lit_set(input int d);
    string s;
    logic [6:0] m = '0;
    case (d)
      0: s = "fedcba"; 1: s = "cb";    2: s = "gedba";  3: s = "gdcba";
      4: s = "gfcb";   5: s = "gfdca"; 6: s = "gfedca"; 7: s = "cba";
      8: s = "gfedcba"; 9: s = "gfdcba"; default: s = "";
    endcase
    for (int i = 0; i < s.len(); i++) m[s[i] - "a"] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] model(input int d, input bit lt, input bit dk, input bit zi);
    if (!lt) return {1'b1, 7'h00};
    if (!dk) return {1'b1, 7'h7F};
    if (!zi && d == 0) return {1'b0, 7'h7F};
    return {1'b1, ~lit_set(d)};
  endfunction

  task automatic drive(input int d, input bit lt, input bit dk, input bit zi, input string tag);
    @(negedge clk);
    digit = d[3:0]; lt_n = lt; dk_n = dk; zi_n = zi;
    exp_q.push_back(model(d, lt, dk, zi));
    tag_q.push_back(tag);
  endtask

  // Monitor: result for the inputs driven at a negedge appears after the next posedge.
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({zo_n, seg_n} !== e) begin
        errors++;
        $display("FAIL %s: got zsup=%b seg=%b expected zsup=%b seg=%b", t, zo_n, seg_n, e[7], e[6:0]);
      end
    end
  end

  initial begin
    int wd = 0;
    while (!done && wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R7: reset state while reset is held, even with lamp check requested.
    lt_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({zo_n, seg_n} !== 8'hFF) begin
      errors++;
      $display("FAIL R7 reset: got zsup=%b seg=%b expected zsup=1 seg=1111111", zo_n, seg_n);
    end
    @(negedge clk);
    lt_n = 1'b1;
    rst_n = 1'b1;

    for (int d = 0; d < 10; d++) drive(d, 1, 1, 1, "R1 glyph");
    for (int d = 10; d < 16; d++) drive(d, 1, 1, 1, "R2 high code");
    for (int d = 0; d < 16; d += 3) drive(d, 0, 1, 1, "R3 lamp check");
    drive(0, 0, 0, 0, "R3 lamp over dark and suppress");
    drive(5, 0, 0, 1, "R3 lamp over dark");
    for (int d = 0; d < 16; d += 4) drive(d, 1, 0, 1, "R4 dark");
    drive(0, 1, 0, 0, "R4 dark with suppress on zero");
    drive(0, 1, 1, 0, "R5 zero suppressed");
    drive(0, 1, 1, 0, "R5 zero suppressed repeat");
    for (int d = 1; d < 16; d += 2) drive(d, 1, 1, 0, "R6 nonzero with suppress in");
    drive(0, 1, 1, 1, "R6 zero shown");
    // R7: back-to-back changes, each result from the prior cycle's inputs.
    drive(8, 1, 1, 1, "R7 pipeline 8");
    drive(0, 1, 1, 0, "R7 pipeline suppress");
    drive(1, 1, 1, 1, "R7 pipeline 1");
    drive(6, 1, 1, 1, "R7 pipeline 6");
    drive(9, 1, 1, 1, "R7 pipeline 9");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule